// File: doc/BRIEF.md
# Display Raster Timing Generator

This block produces the raster timing for one display output on the pixel clock. It generates horizontal sync, vertical sync and data enable, and it drives the pixel bus with stream pixels, a padding colour or a starvation colour. It keeps a horizontal pixel counter and a linear counter of the pixel position within the frame. The vertical display window is a range of that linear position. An hsync skew can shift the range. An optional panel-trim mode narrows the range.

The horizontal active width can be reduced by a compression ratio. The downstream link then carries fewer pixel clocks per line. All timing fields are copied into a shadow set at each frame boundary, so a frame never mixes two configurations. Pixels come in on a valid/ready stream. Ready is offered only in clocks that display a real pixel. The source may hold valid low at any time. The generator does not wait for it: it shows the starvation colour and sets a sticky flag. Padding clocks never take a pixel.

Timing fields must be non-zero where a total or a width depends on them. The horizontal total must fit in the field width.

Top module: `disp_timing_gen`

## Requirements
- R1: The line length is htot = hsync width + back porch + padded width + front porch pixel clocks. hsync is high while the horizontal position x (0 at line start) is below the hsync width.
- R2: Both the active width and the padded width (active + horizontal pad) are divided by the compression ratio, rounding down. The ratio is 1 when compression is disabled or the ratio field is 0.
- R3: The horizontal window covers x from hsync width + back porch up to htot − front porch − 1, inclusive.
- R4: The frame lasts vtot × htot clocks, where vtot = vsync width + vertical back porch + active lines + vertical pad + vertical front porch. vsync is high for the first vsync width × htot clocks of the frame.
- R5: Let p be the linear frame position (0 at frame start). The display window is p from (vsync width + vertical back porch) × htot + skew up to (vtot − vertical front porch) × htot + skew − 1, inclusive. de is high only when both the display window and the horizontal window hold.
- R6: With panel trim set, the display window start moves later by hsync width + back porch. Its end moves earlier by the front porch.
- R7: hctl_word = {htot, hsync width}, with htot in bits 31:16. hwin_word = {window end x, window start x}, with the end x in bits 31:16.
- R8: A clock is unpadded when x < window start x + divided active width and p < window start p + active lines × htot. pix_in_ready is high exactly when de is high and the clock is unpadded. In such a clock with pix_in_valid high, pix_out = pix_in_data. When de is high in a padded clock, pix_out = pad_color. When de is low, pix_out is 0.
- R9: When pix_in_ready is high and pix_in_valid is low, pix_out = starve_color. underflow_flag is then set from the next clock and stays set until reset.
- R10: Timing fields are captured only in the clock after reset ends and at the frame wrap (the last position of a frame). Changes at any other time take effect at the next frame.
- R11: In reset, and in the one clock after reset that captures the fields, hsync, vsync, de, pix_in_ready, pix_out and underflow_flag are 0. The first frame starts on the following clock at x = 0, p = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_hsync_w | input | 16 | hsync width in pixel clocks |
| cfg_hback | input | 16 | Horizontal back porch |
| cfg_hfront | input | 16 | Horizontal front porch |
| cfg_hactive | input | 16 | Active width before compression |
| cfg_hpad | input | 16 | Horizontal pad before compression |
| cfg_vsync_w | input | 16 | vsync width in lines |
| cfg_vback | input | 16 | Vertical back porch in lines |
| cfg_vfront | input | 16 | Vertical front porch in lines |
| cfg_vactive | input | 16 | Active lines |
| cfg_vpad | input | 16 | Vertical pad lines |
| cfg_hskew | input | 16 | Skew added to the linear window, in pixel clocks |
| cfg_comp_en | input | 1 | Compression enable |
| cfg_comp_ratio | input | 3 | Compression ratio |
| cfg_panel_trim | input | 1 | Panel-trim mode for the linear window |
| pad_color | input | 24 | Colour for padded clocks inside the window |
| starve_color | input | 24 | Colour shown when the stream has no pixel |
| pix_in_valid | input | 1 | Stream pixel valid |
| pix_in_ready | output | 1 | Stream pixel taken this clock |
| pix_in_data | input | 24 | Stream pixel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_out | output | 24 | Pixel bus to the interface |
| underflow_flag | output | 1 | Sticky starvation flag |
| hctl_word | output | 32 | Packed line period and hsync width |
| hwin_word | output | 32 | Packed horizontal window end and start |

## Verification
The hardest case to reach is a configuration change that arrives in the middle of a frame. The old timing must keep running until the wrap, and the new timing must take over exactly at position 0. The bench changes the ratio and trim fields part way through a frame. Its reference model latches the new fields only when its own frame count wraps, and every output is compared in every clock across that boundary. A second hard case is the combination of skew with panel trim, where the linear window no longer starts or ends on a line boundary. A separate scenario runs that combination against the model.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;
  parameter int unsigned TW = 16;       // width of each timing field
  parameter int unsigned RW = 3;        // width of the compression ratio
  parameter int unsigned FW = 2 * TW;   // width of linear frame positions

  typedef struct packed {
    logic [TW-1:0] hs_w;
    logic [TW-1:0] hbp;
    logic [TW-1:0] hfp;
    logic [TW-1:0] hact;
    logic [TW-1:0] hpad;
    logic [TW-1:0] vs_w;
    logic [TW-1:0] vbp;
    logic [TW-1:0] vfp;
    logic [TW-1:0] vact;
    logic [TW-1:0] vpad;
    logic [TW-1:0] skew;
    logic          comp_en;
    logic [RW-1:0] ratio;
    logic          trim;
  } timing_cfg_t;
endpackage

// File: rtl/disp_timing_calc.sv
// Period and window arithmetic on the shadow field set (purely combinational).
module disp_timing_calc
  import disp_timing_pkg::*;
(
  input  timing_cfg_t   cfg,
  output logic [TW-1:0] htot,
  output logic [TW-1:0] hstart,
  output logic [TW-1:0] hend,
  output logic [TW-1:0] hact_lim,
  output logic [FW-1:0] frame_len,
  output logic [FW-1:0] vs_len,
  output logic [FW-1:0] vstart,
  output logic [FW-1:0] vend,
  output logic [FW-1:0] vact_lim,
  output logic [FW-1:0] hctl_word,
  output logic [FW-1:0] hwin_word
);
  localparam logic [TW-1:0] ONE_T = TW'(1);
  localparam logic [FW-1:0] ONE_F = FW'(1);

  logic [TW-1:0] div, w_act, w_pad;
  logic [FW-1:0] htot_f, vtot_f, vstart_b, vend_b;

  always_comb begin
    div    = (cfg.comp_en && (cfg.ratio != '0)) ? TW'(cfg.ratio) : ONE_T;
    w_act  = cfg.hact / div;
    w_pad  = TW'((FW'(cfg.hact) + FW'(cfg.hpad)) / FW'(div));
    hstart = cfg.hs_w + cfg.hbp;
    htot   = hstart + w_pad + cfg.hfp;
    hend   = htot - cfg.hfp - ONE_T;
    hact_lim = hstart + w_act;

    htot_f    = FW'(htot);
    vtot_f    = FW'(cfg.vs_w) + FW'(cfg.vbp) + FW'(cfg.vact)
              + FW'(cfg.vpad) + FW'(cfg.vfp);
    frame_len = vtot_f * htot_f;
    vs_len    = FW'(cfg.vs_w) * htot_f;
    vstart_b  = (FW'(cfg.vs_w) + FW'(cfg.vbp)) * htot_f + FW'(cfg.skew);
    vend_b    = (vtot_f - FW'(cfg.vfp)) * htot_f + FW'(cfg.skew) - ONE_F;

    if (cfg.trim) begin
      vstart = vstart_b + FW'(hstart);
      vend   = vend_b - FW'(cfg.hfp);
    end else begin
      vstart = vstart_b;
      vend   = vend_b;
    end
    vact_lim  = vstart + FW'(cfg.vact) * htot_f;

    hctl_word = {htot, cfg.hs_w};
    hwin_word = {hend, hstart};
  end
endmodule

// File: rtl/disp_timing_cnt.sv
// Horizontal and linear frame-position counters with the one-clock priming step.
module disp_timing_cnt
  import disp_timing_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] htot,
  input  logic [FW-1:0] frame_len,
  output logic [TW-1:0] hcnt,
  output logic [FW-1:0] pos,
  output logic          primed,
  output logic          frame_wrap
);
  localparam logic [TW-1:0] ONE_T = TW'(1);
  localparam logic [FW-1:0] ONE_F = FW'(1);

  logic line_end;
  assign line_end   = (hcnt == htot - ONE_T);
  assign frame_wrap = primed && (pos == frame_len - ONE_F);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      hcnt   <= '0;
      pos    <= '0;
    end else if (!primed) begin
      primed <= 1'b1;
    end else if (frame_wrap) begin
      hcnt <= '0;
      pos  <= '0;
    end else begin
      pos  <= pos + ONE_F;
      hcnt <= line_end ? '0 : hcnt + ONE_T;
    end
  end

  // R1: the horizontal position stays inside the line
  assert_hcnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (hcnt < htot));
  // R4: a frame starts on a line start
  assert_frame_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && pos == '0) |-> (hcnt == '0));
  // R4: the last frame position is the last clock of a line
  assert_wrap_at_line_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |-> line_end);
endmodule

// File: rtl/disp_window_dec.sv
// Sync pulses, display window and unpadded-area decode.
module disp_window_dec
  import disp_timing_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          primed,
  input  logic [TW-1:0] hcnt,
  input  logic [FW-1:0] pos,
  input  logic [TW-1:0] hs_w,
  input  logic [TW-1:0] hstart,
  input  logic [TW-1:0] hend,
  input  logic [TW-1:0] hact_lim,
  input  logic [FW-1:0] vs_len,
  input  logic [FW-1:0] vstart,
  input  logic [FW-1:0] vend,
  input  logic [FW-1:0] vact_lim,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          in_unpad
);
  logic h_in, v_in;

  always_comb begin
    h_in     = (hcnt >= hstart) && (hcnt <= hend);
    v_in     = (pos >= vstart) && (pos <= vend);
    hsync    = primed && (hcnt < hs_w);
    vsync    = primed && (pos < vs_len);
    de       = primed && h_in && v_in;
    in_unpad = (hcnt < hact_lim) && (pos < vact_lim);
  end

  // R3: data enable never overlaps the horizontal pulse
  assert_de_clear_of_hsync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !hsync);
  // R5: data enable never overlaps the vertical pulse
  assert_de_clear_of_vsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !vsync);
endmodule

// File: rtl/disp_pixel_sel.sv
// Colour selection, stream ready and sticky starvation flag.
module disp_pixel_sel #(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de,
  input  logic             in_unpad,
  input  logic [PIX_W-1:0] pad_color,
  input  logic [PIX_W-1:0] starve_color,
  input  logic             pix_in_valid,
  input  logic [PIX_W-1:0] pix_in_data,
  output logic             pix_in_ready,
  output logic [PIX_W-1:0] pix_out,
  output logic             underflow_flag
);
  logic starve;

  always_comb begin
    pix_in_ready = de && in_unpad;
    starve       = pix_in_ready && !pix_in_valid;
    if (!de)               pix_out = '0;
    else if (!in_unpad)    pix_out = pad_color;
    else if (pix_in_valid) pix_out = pix_in_data;
    else                   pix_out = starve_color;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      underflow_flag <= 1'b0;
    else if (starve) underflow_flag <= 1'b1;
  end

  // R8: the stream is only consumed inside the display window
  assert_ready_in_de_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_in_ready |-> de);
  // R9: a missing pixel raises the flag on the next clock
  assert_underflow_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_in_ready && !pix_in_valid) |=> underflow_flag);
  // R9: the flag never drops outside reset
  assert_underflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_flag |=> underflow_flag);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import disp_timing_pkg::*;
#(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    cfg_hsync_w,
  input  logic [TW-1:0]    cfg_hback,
  input  logic [TW-1:0]    cfg_hfront,
  input  logic [TW-1:0]    cfg_hactive,
  input  logic [TW-1:0]    cfg_hpad,
  input  logic [TW-1:0]    cfg_vsync_w,
  input  logic [TW-1:0]    cfg_vback,
  input  logic [TW-1:0]    cfg_vfront,
  input  logic [TW-1:0]    cfg_vactive,
  input  logic [TW-1:0]    cfg_vpad,
  input  logic [TW-1:0]    cfg_hskew,
  input  logic             cfg_comp_en,
  input  logic [RW-1:0]    cfg_comp_ratio,
  input  logic             cfg_panel_trim,
  input  logic [PIX_W-1:0] pad_color,
  input  logic [PIX_W-1:0] starve_color,
  input  logic             pix_in_valid,
  output logic             pix_in_ready,
  input  logic [PIX_W-1:0] pix_in_data,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [PIX_W-1:0] pix_out,
  output logic             underflow_flag,
  output logic [FW-1:0]    hctl_word,
  output logic [FW-1:0]    hwin_word
);
  timing_cfg_t   cfg_in, shadow;
  logic [TW-1:0] htot, hstart, hend, hact_lim, hcnt;
  logic [FW-1:0] frame_len, vs_len, vstart, vend, vact_lim, pos;
  logic          primed, frame_wrap, in_unpad;

  always_comb begin
    cfg_in.hs_w    = cfg_hsync_w;
    cfg_in.hbp     = cfg_hback;
    cfg_in.hfp     = cfg_hfront;
    cfg_in.hact    = cfg_hactive;
    cfg_in.hpad    = cfg_hpad;
    cfg_in.vs_w    = cfg_vsync_w;
    cfg_in.vbp     = cfg_vback;
    cfg_in.vfp     = cfg_vfront;
    cfg_in.vact    = cfg_vactive;
    cfg_in.vpad    = cfg_vpad;
    cfg_in.skew    = cfg_hskew;
    cfg_in.comp_en = cfg_comp_en;
    cfg_in.ratio   = cfg_comp_ratio;
    cfg_in.trim    = cfg_panel_trim;
  end

  // Shadow set: captured on the priming clock and at each frame wrap only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       shadow <= '0;
    else if (!primed || frame_wrap)   shadow <= cfg_in;
  end

  disp_timing_calc u_calc (
    .cfg(shadow), .htot(htot), .hstart(hstart), .hend(hend), .hact_lim(hact_lim),
    .frame_len(frame_len), .vs_len(vs_len), .vstart(vstart), .vend(vend),
    .vact_lim(vact_lim), .hctl_word(hctl_word), .hwin_word(hwin_word)
  );

  disp_timing_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .htot(htot), .frame_len(frame_len),
    .hcnt(hcnt), .pos(pos), .primed(primed), .frame_wrap(frame_wrap)
  );

  disp_window_dec u_win (
    .clk(clk), .rst_n(rst_n), .primed(primed), .hcnt(hcnt), .pos(pos),
    .hs_w(shadow.hs_w), .hstart(hstart), .hend(hend), .hact_lim(hact_lim),
    .vs_len(vs_len), .vstart(vstart), .vend(vend), .vact_lim(vact_lim),
    .hsync(hsync), .vsync(vsync), .de(de), .in_unpad(in_unpad)
  );

  disp_pixel_sel #(.PIX_W(PIX_W)) u_pix (
    .clk(clk), .rst_n(rst_n), .de(de), .in_unpad(in_unpad),
    .pad_color(pad_color), .starve_color(starve_color),
    .pix_in_valid(pix_in_valid), .pix_in_data(pix_in_data),
    .pix_in_ready(pix_in_ready), .pix_out(pix_out), .underflow_flag(underflow_flag)
  );

  // R10: the shadow set holds still except at a capture point
  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !frame_wrap) |=> $stable(shadow));
endmodule

// File: tb/disp_timing_gen_tb.sv
`timescale 1ns/1ps
module disp_timing_gen_tb;
  import disp_timing_pkg::*;
  localparam int PIX_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  timing_cfg_t cur, act;
  logic [PIX_W-1:0] pad_c = 24'h0A0B0C;
  logic [PIX_W-1:0] stv_c = 24'hFF00FF;
  logic pix_in_valid = 1'b0;
  logic [PIX_W-1:0] pix_in_data = '0;
  logic pix_in_ready, hsync, vsync, de, underflow_flag;
  logic [PIX_W-1:0] pix_out;
  logic [FW-1:0] hctl_word, hwin_word;

  int n_chk = 0, n_fail = 0, t = 0, cyc = 0;
  bit e_flag = 0, done = 0;
  int m_htot, m_hstart, m_hend, m_hlim, m_frame, m_vslen, m_vstart, m_vend, m_vlim;

  always #2.5 clk = ~clk;

  disp_timing_gen #(.PIX_W(PIX_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_hsync_w(cur.hs_w), .cfg_hback(cur.hbp), .cfg_hfront(cur.hfp),
    .cfg_hactive(cur.hact), .cfg_hpad(cur.hpad), .cfg_vsync_w(cur.vs_w),
    .cfg_vback(cur.vbp), .cfg_vfront(cur.vfp), .cfg_vactive(cur.vact),
    .cfg_vpad(cur.vpad), .cfg_hskew(cur.skew), .cfg_comp_en(cur.comp_en),
    .cfg_comp_ratio(cur.ratio), .cfg_panel_trim(cur.trim),
    .pad_color(pad_c), .starve_color(stv_c),
    .pix_in_valid(pix_in_valid), .pix_in_ready(pix_in_ready), .pix_in_data(pix_in_data),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out),
    .underflow_flag(underflow_flag), .hctl_word(hctl_word), .hwin_word(hwin_word)
  );

  task automatic chk(string req, string what, longint actual, longint expect_v);
    n_chk++;
    if (actual != expect_v) begin
      n_fail++;
      $display("FAIL %s %s at t=%0d: got %0h expected %0h", req, what, t, actual, expect_v);
    end
  endtask

  // Reference arithmetic from the requirements, on the bench's own active set.
  task automatic derive();
    int r, wpad, vtot;
    r = (act.comp_en && act.ratio != 0) ? int'(act.ratio) : 1;          // R2
    wpad = (int'(act.hact) + int'(act.hpad)) / r;
    m_hstart = int'(act.hs_w) + int'(act.hbp);
    m_htot = m_hstart + wpad + int'(act.hfp);                            // R1
    m_hend = m_htot - int'(act.hfp) - 1;                                 // R3
    m_hlim = m_hstart + int'(act.hact) / r;
    vtot = int'(act.vs_w) + int'(act.vbp) + int'(act.vact) + int'(act.vpad) + int'(act.vfp);
    m_frame = vtot * m_htot;                                             // R4
    m_vslen = int'(act.vs_w) * m_htot;
    m_vstart = (int'(act.vs_w) + int'(act.vbp)) * m_htot + int'(act.skew); // R5
    m_vend = (vtot - int'(act.vfp)) * m_htot + int'(act.skew) - 1;
    if (act.trim) begin                                                  // R6
      m_vstart += m_hstart;
      m_vend -= int'(act.hfp);
    end
    m_vlim = m_vstart + int'(act.vact) * m_htot;
  endtask

  task automatic check_words(string req);
    chk(req, "hctl_word", longint'(hctl_word), (longint'(m_htot) << 16) | longint'(act.hs_w));
    chk(req, "hwin_word", longint'(hwin_word), (longint'(m_hend) << 16) | longint'(m_hstart));
  endtask

  // One pixel clock: drive at the falling edge, compare, then advance the model.
  task automatic step(int mode, string de_req);
    int h;
    bit v, e_de, e_un, e_rdy;
    logic [PIX_W-1:0] d, e_pix;
    h = t % m_htot;
    v = (mode == 0) ? 1'b1 : (mode == 1) ? bit'(cyc % 2 == 0) : 1'b0;
    d = PIX_W'(cyc * 7 + 1);
    pix_in_valid = v;
    pix_in_data = d;
    #1;
    e_de = (h >= m_hstart) && (h <= m_hend) && (t >= m_vstart) && (t <= m_vend);
    e_un = (h < m_hlim) && (t < m_vlim);
    e_rdy = e_de && e_un;
    e_pix = !e_de ? '0 : !e_un ? pad_c : v ? d : stv_c;
    chk("R1", "hsync", longint'(hsync), longint'(h < int'(act.hs_w)));
    chk("R4", "vsync", longint'(vsync), longint'(t < m_vslen));
    chk(de_req, "de", longint'(de), longint'(e_de));
    chk("R8", "pix_in_ready", longint'(pix_in_ready), longint'(e_rdy));
    chk((e_rdy && !v) ? "R9" : "R8", "pix_out", longint'(pix_out), longint'(e_pix));
    chk("R9", "underflow_flag", longint'(underflow_flag), longint'(e_flag));
    @(posedge clk);
    if (e_rdy && !v) e_flag = 1;
    t++;
    cyc++;
    if (t == m_frame) begin
      t = 0;
      act = cur;                                                         // R10
      derive();
    end
    @(negedge clk);
  endtask

  task automatic run_cycles(int n, int mode, string de_req);
    for (int i = 0; i < n; i++) step(mode, de_req);
  endtask

  task automatic run_to_wrap(int mode, string de_req);
    int n;
    n = m_frame - t;
    run_cycles(n, mode, de_req);
  endtask

  task automatic check_idle(string req);
    chk(req, "hsync", longint'(hsync), 0);
    chk(req, "vsync", longint'(vsync), 0);
    chk(req, "de", longint'(de), 0);
    chk(req, "pix_in_ready", longint'(pix_in_ready), 0);
    chk(req, "pix_out", longint'(pix_out), 0);
    chk(req, "underflow_flag", longint'(underflow_flag), 0);
  endtask

  task automatic test_reset_r11();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R11");
    rst_n = 1;
    #1;
    check_idle("R11");             // priming clock: still idle
    @(posedge clk);
    act = cur;
    derive();
    t = 0;
    e_flag = 0;
    @(negedge clk);
  endtask

  task automatic test_plain_r3();
    check_words("R7");
    run_to_wrap(0, "R5");
    run_to_wrap(0, "R3");
  endtask

  task automatic test_compress_r2();
    int old_htot;
    old_htot = m_htot;
    run_cycles(m_frame / 2, 0, "R5");
    cur.comp_en = 1'b1;
    cur.ratio = 3'd2;
    run_cycles(5, 0, "R10");
    chk("R10", "htot held", longint'(hctl_word >> 16), longint'(old_htot));
    run_to_wrap(0, "R10");
    check_words("R2");
    run_to_wrap(0, "R2");
    cur.ratio = 3'd0;               // ratio 0 behaves as 1
    run_to_wrap(0, "R2");
    check_words("R2");
    run_to_wrap(0, "R2");
  endtask

  task automatic test_trim_r6();
    cur.trim = 1'b1;
    cur.skew = 16'd3;
    cur.comp_en = 1'b1;
    cur.ratio = 3'd2;
    run_to_wrap(0, "R6");
    check_words("R7");
    run_to_wrap(0, "R6");
    cur.ratio = 3'd1;
    run_to_wrap(0, "R6");
    run_to_wrap(0, "R6");
  endtask

  task automatic test_underflow_r9();
    chk("R9", "flag clear before starvation", longint'(underflow_flag), 0);
    run_to_wrap(1, "R5");
    chk("R9", "flag after starvation", longint'(underflow_flag), 1);
    run_cycles(m_frame / 2, 2, "R5");
    run_to_wrap(0, "R5");
    chk("R9", "flag still set", longint'(underflow_flag), 1);
  endtask

  initial begin
    cur = '0;
    cur.hs_w = 16'd2; cur.hbp = 16'd3; cur.hfp = 16'd2;
    cur.hact = 16'd8; cur.hpad = 16'd2;
    cur.vs_w = 16'd1; cur.vbp = 16'd2; cur.vfp = 16'd1;
    cur.vact = 16'd4; cur.vpad = 16'd1;
    act = cur;
    derive();
    test_reset_r11();
    test_plain_r3();
    test_compress_r2();
    test_underflow_r9();
    test_trim_r6();
    rst_n = 0;
    #1;
    check_idle("R11");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule